// File: doc/BRIEF.md
# Narrow to Long-Word Write Packer

This block sits between a narrow write port and a FIFO memory that stores only 36-bit long words. The narrow port carries either 9-bit bytes or 18-bit words. Each accepted narrow write supplies one piece of a long word. The block holds the earlier pieces in auxiliary lane registers. On the clock edge that brings the final piece (the fourth byte or the second word), the block presents the complete long word to the memory with a one-cycle write strobe.

Two settings are fixed for the whole period between resets: the piece size and the lane order. They are sampled while reset is low, and the value present at the last reset clock edge stays in force after reset is released. In big-endian order the first piece of a long word goes to the most significant lane. In little-endian order it goes to the least significant lane. The piece counter starts at zero after reset and returns to zero after each committed long word. The port accepts a write only while the memory reports that it is not full.

Top module: `pk_packer`

## Requirements
- R1: While reset is low, and after its release until the first accepted write, `mem_wr_o` stays 0. The piece counter starts at zero, so a fresh long word begins with the first write after reset.
- R2: In word mode (`size_byte_i`=0 at reset), the first accepted write of a long word gives no strobe. The second accepted write raises `mem_wr_o` in the same cycle, before the edge that takes it.
- R3: In byte mode (`size_byte_i`=1 at reset), the first three accepted writes give no strobe, and the fourth raises `mem_wr_o` in its own cycle.
- R4: Big-endian bytes (`big_end_i`=1): the four bytes of a long word land at `mem_data_o[35:27]`, `[26:18]`, `[17:9]` and `[8:0]`, in the order they were written.
- R5: Little-endian bytes (`big_end_i`=0): the four bytes land at `mem_data_o[8:0]`, `[17:9]`, `[26:18]` and `[35:27]`, in the order they were written.
- R6: Big-endian words: the first word lands at `mem_data_o[35:18]` and the second at `[17:0]`, with the bit order inside each word kept.
- R7: Little-endian words: the first word lands at `mem_data_o[17:0]` and the second at `[35:18]`.
- R8: In byte mode only `wr_data_i[8:0]` is used, and bits 17:9 have no effect on the committed long word.
- R9: A write offered while `mem_full_i`=1 is not accepted. It gives no strobe, does not advance the piece count and contributes no data.
- R10: Piece size and endian order keep the values sampled at the last reset edge. Changing `size_byte_i` or `big_end_i` after reset release has no effect.
- R11: After each commit the piece count returns to zero, so back-to-back long words stay aligned. `mem_wr_o` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous master reset; settings are sampled while it is low |
| size_byte_i | input | 1 | Piece size: 1 = 9-bit bytes, 0 = 18-bit words |
| big_end_i | input | 1 | Lane order: 1 = first piece in the most significant lane |
| wr_en_i | input | 1 | Narrow write request |
| wr_data_i | input | 18 | Narrow write data |
| mem_full_i | input | 1 | Memory full; blocks acceptance |
| mem_wr_o | output | 1 | Long-word write strobe for the memory |
| mem_data_o | output | 36 | Assembled long word, valid when `mem_wr_o` is 1 |

## Verification
A piece counter that is off by one shows up at the ports on the very next long word. The strobe appears one write too early or too late, and every later long word comes out rotated by one lane. A wrong lane-order or size setting shows up on the first commit after reset as bytes or words in mirrored or doubled positions. A stale auxiliary lane shows up only in a long word where that lane should have been freshly written, so the directed tests change every lane from one long word to the next.

// File: rtl/pk_pkg.sv
package pk_pkg;

    typedef struct packed {
        logic byte_mode;
        logic big_end;
    } pk_cfg_t;

endpackage

// File: rtl/pk_lane_map.sv
module pk_lane_map #(
    parameter int LANES = 4,
    parameter int CNT_W = 2
) (
    input  pk_pkg::pk_cfg_t    cfg,
    input  logic [CNT_W-1:0]   cnt,
    output logic [LANES-1:0]   hit,
    output logic [LANES-1:0]   use_hi
);

    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(LANES - 1);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(LANES / 2 - 1);

    logic [CNT_W-1:0] byte_tgt;
    logic [CNT_W-1:0] word_tgt;

    always_comb begin
        byte_tgt = cfg.big_end ? (LAST_BYTE - cnt) : cnt;
        word_tgt = cfg.big_end ? (LAST_WORD - cnt) : cnt;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign hit[l]    = cfg.byte_mode ? (byte_tgt == CNT_W'(l))
                                         : (word_tgt == CNT_W'(l / 2));
        assign use_hi[l] = !cfg.byte_mode && ((l % 2) == 1);
    end

endmodule

// File: rtl/pk_merge.sv
module pk_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] aux,
    input  logic [2*LANE_W-1:0]     piece,
    input  logic [LANES-1:0]        hit,
    input  logic [LANES-1:0]        use_hi,
    output logic [LANES*LANE_W-1:0] merged
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] src;
        assign src = use_hi[l] ? piece[LANE_W +: LANE_W] : piece[0 +: LANE_W];
        assign merged[l*LANE_W +: LANE_W] = hit[l] ? src : aux[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/pk_packer.sv
module pk_packer #(
    parameter  int LANE_W   = 9,
    parameter  int LANES    = 4,
    localparam int NARROW_W = 2 * LANE_W,
    localparam int LONG_W   = LANES * LANE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                size_byte_i,
    input  logic                big_end_i,
    input  logic                wr_en_i,
    input  logic [NARROW_W-1:0] wr_data_i,
    input  logic                mem_full_i,
    output logic                mem_wr_o,
    output logic [LONG_W-1:0]   mem_data_o
);

    localparam int               CNT_W     = $clog2(LANES);
    localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(LANES - 1);
    localparam logic [CNT_W-1:0] LAST_WORD = CNT_W'(LANES / 2 - 1);

    typedef struct packed {
        pk_pkg::pk_cfg_t   cfg;
        logic [CNT_W-1:0]  cnt;
        logic [LONG_W-1:0] aux;
    } st_t;

    st_t st_d, st_q;

    logic              accept;
    logic              last;
    logic [LANES-1:0]  hit;
    logic [LANES-1:0]  use_hi;
    logic [LONG_W-1:0] merged;

    // names seen by the bound checker
    logic [CNT_W-1:0]  cnt_q;
    pk_pkg::pk_cfg_t   cfg_q;
    assign cnt_q = st_q.cnt;
    assign cfg_q = st_q.cfg;

    pk_lane_map #(.LANES(LANES), .CNT_W(CNT_W)) map_i (
        .cfg    (st_q.cfg),
        .cnt    (st_q.cnt),
        .hit    (hit),
        .use_hi (use_hi)
    );

    pk_merge #(.LANES(LANES), .LANE_W(LANE_W)) merge_i (
        .aux    (st_q.aux),
        .piece  (wr_data_i),
        .hit    (hit),
        .use_hi (use_hi),
        .merged (merged)
    );

    always_comb begin
        st_d   = st_q;
        accept = wr_en_i && !mem_full_i;
        last   = st_q.cnt == (st_q.cfg.byte_mode ? LAST_BYTE : LAST_WORD);
        if (accept) begin
            if (last) begin
                st_d.cnt = '0;
                st_d.aux = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                st_d.aux = merged;
            end
        end
        mem_wr_o   = accept && last;
        mem_data_o = merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg.byte_mode <= size_byte_i;
            st_q.cfg.big_end   <= big_end_i;
            st_q.cnt           <= '0;
            st_q.aux           <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pk_packer_chk.sv
module pk_packer_chk #(
    parameter int LANES = 4,
    parameter int CNT_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             mem_full,
    input logic             mem_wr,
    input logic [CNT_W-1:0] cnt,
    input pk_pkg::pk_cfg_t  cfg
);

    p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_full |-> !mem_wr);

    p_hold_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !mem_full) |=> $stable(cnt));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mem_full && !mem_wr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    p_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (cnt == '0));

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);

    p_cfg_static_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg));

    p_word_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.byte_mode |-> (cnt < CNT_W'(LANES / 2)));

endmodule

bind pk_packer pk_packer_chk #(.LANES(LANES), .CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .mem_full (mem_full_i),
    .mem_wr   (mem_wr_o),
    .cnt      (cnt_q),
    .cfg      (cfg_q)
);

// File: tb/pk_packer_tb_top.sv
module pk_packer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        size_byte = 1'b0;
    logic        big_end = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_data = '0;
    logic        mem_full = 1'b0;
    logic        mem_wr;
    logic [35:0] mem_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pk_packer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .size_byte_i (size_byte),
        .big_end_i   (big_end),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .mem_full_i  (mem_full),
        .mem_wr_o    (mem_wr),
        .mem_data_o  (mem_data)
    );

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // reset with the given settings, then flip the setting inputs
    task automatic do_reset(input logic byte_m, input logic big);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; mem_full = 1'b0;
        size_byte = byte_m; big_end = big;
        repeat (3) begin
            @(negedge clk);
            chk("R1 strobe in reset", 36'(mem_wr), 36'd0);
        end
        rst_n = 1'b1;
        size_byte = ~byte_m; big_end = ~big;
    endtask

    // one narrow write; sampled 1 ns after the drive, before the taking edge
    task automatic put(input logic [17:0] d, input logic full, input logic exp_wr,
                       input logic [35:0] exp_d, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; mem_full = full;
        #1;
        chk(req, 36'(mem_wr), 36'(exp_wr));
        if (exp_wr) chk(req, mem_data, exp_d);
        @(posedge clk);
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en = 1'b0; mem_full = 1'b0;
        #1;
        chk("R11 idle strobe", 36'(mem_wr), 36'd0);
    endtask

    task automatic t_reset();
        do_reset(1'b0, 1'b1);
        idle();
        put(18'h0_0011, 1'b0, 1'b0, '0, "R1 first write after reset");
        put(18'h0_0022, 1'b0, 1'b1, {18'h0_0011, 18'h0_0022}, "R1 commit after reset");
        idle();
    endtask

    task automatic t_word(input logic big);
        logic [17:0] w0 = 18'h3_0A5C;
        logic [17:0] w1 = 18'h1_C3F0;
        do_reset(1'b0, big);
        put(w0, 1'b0, 1'b0, '0, "R2 first word");
        put(w1, 1'b0, 1'b1, big ? {w0, w1} : {w1, w0}, big ? "R6 big word" : "R7 little word");
        idle();
    endtask

    task automatic t_byte(input logic big);
        logic [8:0] b[4] = '{9'h1A5, 9'h03C, 9'h1F0, 9'h0E7};
        logic [35:0] exp;
        exp = big ? {b[0], b[1], b[2], b[3]} : {b[3], b[2], b[1], b[0]};
        do_reset(1'b1, big);
        for (int k = 0; k < 4; k++)
            put({9'(9'h155 + k), b[k]}, 1'b0, k == 3, exp,
                big ? "R4 R8 big bytes" : "R5 R8 little bytes");
        chk("R3 count", 36'(checks > 0), 36'd1);
        idle();
    endtask

    task automatic t_full();
        do_reset(1'b1, 1'b1);
        put(18'h0_0101, 1'b0, 1'b0, '0, "R9 piece0");
        put(18'h0_0102, 1'b0, 1'b0, '0, "R9 piece1");
        put(18'h0_01FF, 1'b1, 1'b0, '0, "R9 blocked");
        put(18'h0_0103, 1'b0, 1'b0, '0, "R9 piece2");
        put(18'h0_01EE, 1'b1, 1'b0, '0, "R9 blocked last");
        put(18'h0_0104, 1'b0, 1'b1, {9'h101, 9'h102, 9'h103, 9'h104}, "R9 commit");
        idle();
    endtask

    task automatic t_latch();
        do_reset(1'b0, 1'b1);
        put(18'h2_2222, 1'b0, 1'b0, '0, "R10 word kept");
        put(18'h1_1111, 1'b0, 1'b1, {18'h2_2222, 18'h1_1111}, "R10 order kept");
        idle();
    endtask

    task automatic t_wrap();
        do_reset(1'b1, 1'b0);
        for (int n = 0; n < 3; n++) begin
            logic [8:0] b[4];
            for (int k = 0; k < 4; k++) b[k] = 9'(n * 64 + k * 13 + 5);
            for (int k = 0; k < 4; k++)
                put({9'h0, b[k]}, 1'b0, k == 3, {b[3], b[2], b[1], b[0]}, "R11 back to back");
        end
        idle();
    endtask

    initial begin
        t_reset();
        t_word(1'b1);
        t_word(1'b0);
        t_byte(1'b1);
        t_byte(1'b0);
        t_full();
        t_latch();
        t_wrap();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule